// File: doc/BRIEF.md
# Priority Interrupt Presenter Context

This block keeps the per-thread presenter state for a single operating-system ring of an interrupt controller. Incoming notifications each carry a priority. Each one marks a bit in an eight-level pending bitmap. The most favored pending level is found by scanning that bitmap from its top bit, and it is held in a pending-priority register. The pending priority is compared against the current processor priority (CPPR), which the operating system programs. When the pending level is more favored, the block records an outstanding exception and raises its interrupt line.

Software takes an interrupt with an acknowledge read. The read returns the status byte as it was before the read, together with the resulting CPPR. If an exception was outstanding, the read moves the pending priority into the CPPR, retires that level's pending bit and clears the exception.

Control follows a two-state machine:
- **ST_QUIET** means no exception is outstanding.
- **ST_RAISED** means an exception is outstanding.
- **QUIET→RAISED** is taken when the updated state shows a favored pending level.
- **RAISED→QUIET** is taken on an acknowledge that leaves no favored level behind.
- **RAISED→RAISED** is taken on all other cycles, including an acknowledge that is immediately followed by a more favored notification.

Top module: `ipc_presenter`

## Requirements
- R1: Priority 0 is the most favored level, and a smaller value is more favored. A notify at priority p (0..7) sets pending bit 7−p, so priority 0 lands in bit 7. The pending priority is the number of leading zeros of the 8-bit pending bitmap, or 0xFF when the bitmap is empty.
- R2: A notify whose priority is above 7 sets no pending bit and changes nothing.
- R3: When the updated pending priority is strictly less than the updated CPPR, the exception bit is set. The exception bit is bit 7 of the status byte, and the other status bits are always zero. irq_o goes high on the clock edge after the triggering event. An equal priority does not raise the line.
- R4: The comparison is evaluated again on every accepted CPPR write, as well as on every notify.
- R5: A CPPR write is accepted only for values 0..7 and 0xFF. Any other value leaves the CPPR unchanged.
- R6: An acknowledge always drops the interrupt, unless a notify or CPPR write in the same cycle raises it again. If the exception bit was set, the acknowledge does four things: the CPPR takes the pending priority, that level's pending bit is cleared, the pending priority is recomputed, and the exception bit is cleared. If the exception bit was not set, no state changes.
- R7: One cycle after ack_rd_i, ack_valid_o pulses for one cycle. ack_data_o[15:8] holds the status byte from before the acknowledge, and ack_data_o[7:0] holds the CPPR after the acknowledge step. At all other times ack_data_o is zero.
- R8: Once raised, the exception bit and irq_o stay set until an acknowledge, even if a CPPR write makes the pending level no longer favored.
- R9: When events coincide in one cycle, they are applied in this order: the acknowledge first, then the CPPR write, then the notify. The comparison uses the final state, and the returned CPPR byte is the one produced by the acknowledge step.
- R10: Reset clears the pending bitmap, the CPPR and the status, and sets the pending priority to 0xFF. As a result, a first CPPR write of 0xFF raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ntf_valid_i | input | 1 | Notification event strobe |
| ntf_prio_i | input | 8 | Priority carried by the notification |
| cppr_wr_i | input | 1 | CPPR write strobe |
| cppr_wdata_i | input | 8 | Value to write into the CPPR |
| ack_rd_i | input | 1 | Acknowledge read strobe |
| irq_o | output | 1 | Registered interrupt line to the thread |
| ack_valid_o | output | 1 | Acknowledge response valid, one cycle after the read |
| ack_data_o | output | 16 | Status-before in the high byte, CPPR-after in the low byte |

## Verification
The bench targets the following corner cases and the failure each would reveal:
- **Pending priority equal to the CPPR.** A design that compares with less-or-equal would raise an interrupt here.
- **Two levels pending.** A design whose bit mapping or leading-bit scan is reversed would hand out the less favored level first.
- **Out-of-range notify and out-of-range CPPR write.** A design missing these checks would set a stray pending bit or corrupt the CPPR, and a later acknowledge exposes it.
- **Acknowledge together with a more favored notify.** A design that orders these wrongly would lose the new exception.
- **Acknowledge together with a CPPR write.** A design that orders these wrongly would let the acknowledge overwrite the software value.
- **Reset in the middle of a run.** A design that resets the pending priority to zero would raise a phantom interrupt on the first CPPR write after reset.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
    localparam int NUM_LVL   = 8;
    localparam int PRIO_W    = 8;
    localparam int STAT_W    = 8;
    localparam int EXC_BIT   = 7;
    localparam int RESP_W    = STAT_W + PRIO_W;
    localparam logic [PRIO_W-1:0] NO_PRIO = '1;

    typedef enum logic [0:0] {
        ST_QUIET  = 1'b0,
        ST_RAISED = 1'b1
    } ipc_state_e;
endpackage

// File: rtl/ipc_lead_detect.sv
module ipc_lead_detect #(
    parameter int W  = 8,
    parameter int OW = 8
) (
    input  logic [W-1:0]  vec_i,
    output logic [OW-1:0] idx_o
);
    // Leading-zero count: scan from LSB up so the highest set bit wins.
    always_comb begin
        idx_o = '1;
        for (int i = 0; i < W; i++) begin
            if (vec_i[i]) begin
                idx_o = OW'(W - 1 - i);
            end
        end
    end
endmodule

// File: rtl/ipc_pend_buf.sv
module ipc_pend_buf
    import ipc_pkg::*;
#(
    parameter int LVLS = NUM_LVL,
    parameter int PW   = PRIO_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en_i,
    input  logic [PW-1:0] set_prio_i,
    input  logic          clr_en_i,
    input  logic [PW-1:0] clr_prio_i,
    output logic [PW-1:0] pipr_nxt_o,
    output logic [PW-1:0] pipr_q_o
);
    logic [LVLS-1:0] ipb_q;
    logic [LVLS-1:0] ipb_nxt;
    logic [LVLS-1:0] set_mask;
    logic [LVLS-1:0] clr_mask;

    function automatic logic [LVLS-1:0] lvl_mask(input logic [PW-1:0] prio);
        logic [LVLS-1:0] m;
        m = '0;
        for (int i = 0; i < LVLS; i++) begin
            if (prio == PW'(i)) begin
                m[LVLS-1-i] = 1'b1;
            end
        end
        return m;
    endfunction

    always_comb begin
        set_mask = set_en_i ? lvl_mask(set_prio_i) : '0;
        clr_mask = clr_en_i ? lvl_mask(clr_prio_i) : '0;
        // retire first, then post the new notification
        ipb_nxt  = (ipb_q & ~clr_mask) | set_mask;
    end

    ipc_lead_detect #(
        .W  (LVLS),
        .OW (PW)
    ) i_lead (
        .vec_i (ipb_nxt),
        .idx_o (pipr_nxt_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ipb_q    <= '0;
            pipr_q_o <= '1;
        end else begin
            ipb_q    <= ipb_nxt;
            pipr_q_o <= pipr_nxt_o;
        end
    end
endmodule

// File: rtl/ipc_presenter.sv
module ipc_presenter
    import ipc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ntf_valid_i,
    input  logic [PRIO_W-1:0] ntf_prio_i,
    input  logic              cppr_wr_i,
    input  logic [PRIO_W-1:0] cppr_wdata_i,
    input  logic              ack_rd_i,
    output logic              irq_o,
    output logic              ack_valid_o,
    output logic [RESP_W-1:0] ack_data_o
);
    ipc_state_e        state_q, state_nxt;
    logic [PRIO_W-1:0] cppr_q, cppr_after_ack, cppr_nxt;
    logic [PRIO_W-1:0] pipr_q, pipr_nxt;
    logic              exc_set, take_ack, cppr_ok, favored;
    logic [STAT_W-1:0] stat_byte;

    assign exc_set  = (state_q == ST_RAISED);
    assign take_ack = ack_rd_i && exc_set;

    always_comb begin
        stat_byte          = '0;
        stat_byte[EXC_BIT] = exc_set;
    end

    // Step 1: acknowledge; step 2: software CPPR write; step 3: notify.
    assign cppr_after_ack = take_ack ? pipr_q : cppr_q;
    assign cppr_ok        = (cppr_wdata_i < PRIO_W'(NUM_LVL)) || (cppr_wdata_i == NO_PRIO);
    assign cppr_nxt       = (cppr_wr_i && cppr_ok) ? cppr_wdata_i : cppr_after_ack;

    ipc_pend_buf #(
        .LVLS (NUM_LVL),
        .PW   (PRIO_W)
    ) i_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en_i   (ntf_valid_i),
        .set_prio_i (ntf_prio_i),
        .clr_en_i   (take_ack),
        .clr_prio_i (pipr_q),
        .pipr_nxt_o (pipr_nxt),
        .pipr_q_o   (pipr_q)
    );

    assign favored = (pipr_nxt < cppr_nxt);

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_QUIET: begin
                if (favored) state_nxt = ST_RAISED;
            end
            ST_RAISED: begin
                if (ack_rd_i && !favored) state_nxt = ST_QUIET;
            end
            default: state_nxt = ST_QUIET;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
            cppr_q  <= '0;
        end else begin
            state_q <= state_nxt;
            cppr_q  <= cppr_nxt;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o       <= 1'b0;
            ack_valid_o <= 1'b0;
            ack_data_o  <= '0;
        end else begin
            irq_o       <= (state_nxt == ST_RAISED);
            ack_valid_o <= ack_rd_i;
            ack_data_o  <= ack_rd_i ? {stat_byte, cppr_after_ack} : '0;
        end
    end
endmodule

// File: rtl/ipc_presenter_chk.sv
module ipc_presenter_chk
    import ipc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ntf_valid_i,
    input logic [PRIO_W-1:0] ntf_prio_i,
    input logic              cppr_wr_i,
    input logic [PRIO_W-1:0] cppr_wdata_i,
    input logic              ack_rd_i,
    input logic              irq_o,
    input logic              ack_valid_o,
    input logic [RESP_W-1:0] ack_data_o
);
    AST_ACK_DROPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rd_i && !ntf_valid_i && !cppr_wr_i |=> !irq_o); // R6

    AST_ACK_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rd_i |=> ack_valid_o); // R7

    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_rd_i |=> !ack_valid_o && ack_data_o == '0); // R7

    AST_STATUS_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid_o |-> ack_data_o[RESP_W-2:PRIO_W] == '0); // R3

    AST_LINE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !ack_rd_i |=> irq_o); // R8

    AST_QUIET_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o && !ntf_valid_i && !cppr_wr_i && !ack_rd_i |=> !irq_o); // R4

    AST_BAD_PRIO_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o && ntf_valid_i && ntf_prio_i > 8'd7 && !cppr_wr_i && !ack_rd_i |=> !irq_o); // R2

    AST_BAD_CPPR_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o && cppr_wr_i && cppr_wdata_i > 8'd7 && cppr_wdata_i != 8'hFF
        && !ntf_valid_i && !ack_rd_i |=> !irq_o); // R5
endmodule

bind ipc_presenter ipc_presenter_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ntf_valid_i  (ntf_valid_i),
    .ntf_prio_i   (ntf_prio_i),
    .cppr_wr_i    (cppr_wr_i),
    .cppr_wdata_i (cppr_wdata_i),
    .ack_rd_i     (ack_rd_i),
    .irq_o        (irq_o),
    .ack_valid_o  (ack_valid_o),
    .ack_data_o   (ack_data_o)
);

// File: tb/test_ipc_presenter.sv
module test_ipc_presenter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ntf_valid_i = 1'b0;
    logic [7:0]  ntf_prio_i = '0;
    logic        cppr_wr_i = 1'b0;
    logic [7:0]  cppr_wdata_i = '0;
    logic        ack_rd_i = 1'b0;
    logic        irq_o;
    logic        ack_valid_o;
    logic [15:0] ack_data_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    ipc_presenter i_ipc_presenter (
        .clk          (clk),
        .rst_n        (rst_n),
        .ntf_valid_i  (ntf_valid_i),
        .ntf_prio_i   (ntf_prio_i),
        .cppr_wr_i    (cppr_wr_i),
        .cppr_wdata_i (cppr_wdata_i),
        .ack_rd_i     (ack_rd_i),
        .irq_o        (irq_o),
        .ack_valid_o  (ack_valid_o),
        .ack_data_o   (ack_data_o)
    );

    // {ntf_v, ntf_p[8], cppr_w, cppr_d[8], ack, exp_irq, exp_ackv, exp_data[16]}
    localparam int NV = 25;
    localparam logic [36:0] VEC [0:NV-1] = '{
        {1'b0, 8'h00, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 16'h0000}, // R10 no phantom
        {1'b1, 8'h03, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 16'h0000}, // R3
        {1'b1, 8'h05, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 16'h0000}, // R1
        {1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 16'h8003}, // R6 R1
        {1'b1, 8'h01, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 16'h0000}, // R3
        {1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 16'h8001}, // R6
        {1'b0, 8'h00, 1'b1, 8'h06, 1'b0, 1'b1, 1'b0, 16'h0000}, // R4
        {1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 16'h8005}, // R7
        {1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 16'h0005}, // R6 no exception
        {1'b0, 8'h00, 1'b1, 8'h09, 1'b0, 1'b0, 1'b0, 16'h0000}, // R5
        {1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 16'h0005}, // R5 CPPR kept
        {1'b1, 8'h09, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0000}, // R2
        {1'b0, 8'h00, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 16'h0000}, // R2 nothing pending
        {1'b1, 8'h07, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 16'h0000}, // R1 lowest level
        {1'b1, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 16'h8007}, // R9 ack then notify
        {1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 16'h8000}, // R6
        {1'b1, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0000}, // R3 equal not favored
        {1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 16'h0000}, // R7
        {1'b0, 8'h00, 1'b1, 8'h01, 1'b0, 1'b1, 1'b0, 16'h0000}, // R4
        {1'b0, 8'h00, 1'b1, 8'hFF, 1'b0, 1'b1, 1'b0, 16'h0000}, // R8 sticky
        {1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 16'h8000}, // R6
        {1'b0, 8'h00, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 16'h0000}, // R4
        {1'b1, 8'h02, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 16'h0000}, // R3
        {1'b0, 8'h00, 1'b1, 8'h01, 1'b1, 1'b0, 1'b1, 16'h8002}, // R9 ack then write
        {1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 16'h0001}  // R9 write won
    };

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic nv, input logic [7:0] np, input logic cw,
                         input logic [7:0] cd, input logic ak);
        ntf_valid_i  = nv;
        ntf_prio_i   = np;
        cppr_wr_i    = cw;
        cppr_wdata_i = cd;
        ack_rd_i     = ak;
        @(posedge clk);
        @(negedge clk);
        ntf_valid_i = 1'b0;
        cppr_wr_i   = 1'b0;
        ack_rd_i    = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10", "irq in reset", {15'd0, irq_o}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "irq after reset", {15'd0, irq_o}, 16'd0);
        chk("R10", "ack_valid after reset", {15'd0, ack_valid_o}, 16'd0);

        for (int k = 0; k < NV; k++) begin
            drive(VEC[k][36], VEC[k][35:28], VEC[k][27], VEC[k][26:19], VEC[k][18]);
            chk("R3", $sformatf("irq vec %0d", k), {15'd0, irq_o}, {15'd0, VEC[k][17]});
            chk("R7", $sformatf("ack_valid vec %0d", k), {15'd0, ack_valid_o}, {15'd0, VEC[k][16]});
            chk("R7", $sformatf("ack_data vec %0d", k), ack_data_o, VEC[k][15:0]);
        end

        // R10: mid-run reset clears pending state and pending priority
        drive(1'b0, 8'h00, 1'b1, 8'hFF, 1'b0);
        drive(1'b1, 8'h03, 1'b0, 8'h00, 1'b0);
        chk("R3", "irq before reset", {15'd0, irq_o}, 16'd1);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R10", "irq during reset", {15'd0, irq_o}, 16'd0);
        rst_n = 1'b1;
        drive(1'b0, 8'h00, 1'b0, 8'h00, 1'b1);
        chk("R10", "CPPR zero after reset", ack_data_o, 16'h0000);
        drive(1'b0, 8'h00, 1'b1, 8'hFF, 1'b0);
        chk("R10", "no phantom after reset", {15'd0, irq_o}, 16'd0);
        drive(1'b0, 8'h00, 1'b0, 8'h00, 1'b1);
        chk("R10", "ack after reset", ack_data_o, 16'h00FF);

        // R1: with all levels pending, acks deliver them in favored order
        for (int p = 7; p >= 0; p--) drive(1'b1, 8'(p), 1'b0, 8'h00, 1'b0);
        for (int p = 0; p < 8; p++) begin
            drive(1'b0, 8'h00, 1'b0, 8'h00, 1'b1);
            chk("R1", $sformatf("delivery order %0d", p), ack_data_o, {8'h80, 8'(p)});
            drive(1'b0, 8'h00, 1'b1, 8'hFF, 1'b0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule